// File: doc/BRIEF.md
# Repeater False-Carrier Isolation Monitor

This block watches receive carrier activity on a 100 Mb/s repeater port and decides when the port must be cut off from the MII. A port is cut off for one of two reasons. The first is two false carriers in a row with no good frame between them. The second is a single false carrier that runs too long. A false carrier is a carrier event whose opening start-of-stream pair was not decoded correctly; an upstream decoder reports it with a one-cycle pulse. A cut-off port is let back in after a sufficiently long good carrier, or after an unbroken stretch of idle symbols.

The block also keeps a status word for a management reader. The low byte holds a saturating count of false carriers. Bit 15 is a sticky flag that records that a disconnect happened since the last read. A read strobe clears both. All timing is measured in bit times: the block advances its timers only on cycles where the bit-time strobe is high. The port-isolation feature is active only when repeater operation and disconnect capability are both enabled.

Top module: `fcar_isolate_mon`

## Requirements
- R1: After synchronous reset, `mii_isolate` is 0 and `stat_word` is 0.
- R2: `mii_isolate` never rises unless `rptr_en` and `disc_en` are both 1. Dropping either enable while isolated clears `mii_isolate` on the next clock.
- R3: A false event is a cycle with `false_car` and `carrier_on` both high. A second false event with no `good_frame` since the previous one sets `mii_isolate` on the edge that samples it, and sets `stat_word[15]` on the same edge.
- R4: A `good_frame` pulse between two false events clears the history, and the port stays connected.
- R5: Once a false event has opened a carrier, the port isolates on the 484th bit-time strobe that the carrier stays high. It does not isolate on the 483rd. Dropping carrier resets this count.
- R6: While isolated, a carrier that was not opened by a false event and stays high for 480 bit-time strobes clears `mii_isolate` on the 480th strobe. A carrier opened by a false event never reconnects the port.
- R7: While isolated, 27500 bit-time strobes of `idle_sym` high with `carrier_on` low clear `mii_isolate`. Any cycle with carrier high or idle low restarts that window.
- R8: `stat_word[7:0]` counts every false event whatever the enables are, and holds at 255 instead of wrapping.
- R9: On a cycle with `stat_rd` high, the count and bit 15 are cleared on the next edge. A false event in the read cycle leaves the count at 1, and a disconnect in the read cycle leaves bit 15 at 1.
- R10: `stat_word[14:8]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per line bit time |
| carrier_on | input | 1 | Receive carrier present |
| false_car | input | 1 | Current carrier opened with a bad start delimiter |
| good_frame | input | 1 | Pulse on a correctly received frame |
| idle_sym | input | 1 | Idle symbols currently being received |
| rptr_en | input | 1 | Repeater operation enabled |
| disc_en | input | 1 | Disconnect function enabled |
| stat_rd | input | 1 | Status word read strobe (clear on read) |
| mii_isolate | output | 1 | Port cut off from the MII |
| stat_word | output | 16 | Bit 15 sticky disconnect, bits 7:0 false-carrier count |

## Verification
Two collisions get the most attention. The first is a status read landing on the same clock as a new false event. The second is a read landing on the same clock as a disconnect. In both cases the clear-on-read must not swallow the new information. The bench provokes this by raising `stat_rd` together with the second back-to-back false carrier. In the word that follows, it expects a count of exactly 1 with bit 15 set and the port isolated. A second, quiet read must then return all zeros. The thresholds are probed on both sides, one strobe short and exactly on the limit, and the idle window is broken once partway through to prove that it restarts.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic {LINK_ON = 1'b0, LINK_OFF = 1'b1} iso_st_t;
  localparam int STICKY_POS = 15;
endpackage

// File: rtl/fcm_bit_timer.sv
module fcm_bit_timer #(
  parameter int LIMIT = 484
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R5
endmodule

// File: rtl/fcm_evt_count.sv
module fcm_evt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             rd,
  input  logic             dis_evt,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sticky_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (rd) begin
      cnt_o <= inc ? CNT_W'(1) : '0;
    end else if (inc && cnt_o != MAXV) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sticky_o <= 1'b0;
    else if (dis_evt) sticky_o <= 1'b1;
    else if (rd)      sticky_o <= 1'b0;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == MAXV && !rd) |=> cnt_o == MAXV); // R8
  AST_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd && !inc) |=> cnt_o == '0); // R9
  AST_RD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rd && dis_evt) |=> sticky_o); // R9
endmodule

// File: rtl/fcm_iso_ctl.sv
module fcm_iso_ctl
  import fcm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic carrier_on,
  input  logic fc_ev,
  input  logic good_frame,
  input  logic long_hit,
  input  logic good_hit,
  input  logic idle_hit,
  output logic iso,
  output logic in_false,
  output logic dis_evt
);
  iso_st_t st;
  logic    prev_false;
  logic    recon;

  assign iso     = (st == LINK_OFF);
  assign dis_evt = (st == LINK_ON) && en && ((fc_ev && prev_false) || long_hit);
  assign recon   = (st == LINK_OFF) && (!en || good_hit || idle_hit);

  always_ff @(posedge clk) begin
    if (rst)          st <= LINK_ON;
    else if (dis_evt) st <= LINK_OFF;
    else if (recon)   st <= LINK_ON;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || recon) prev_false <= 1'b0;
    else if (fc_ev)          prev_false <= 1'b1;
    else if (good_frame)     prev_false <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)             in_false <= 1'b0;
    else if (fc_ev)      in_false <= 1'b1;
    else if (!carrier_on) in_false <= 1'b0;
  end

  AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !iso); // R2
  AST_CONSEC: assert property (@(posedge clk) disable iff (rst)
    (!iso && en && fc_ev && prev_false) |=> iso); // R3
  AST_RECON: assert property (@(posedge clk) disable iff (rst)
    (iso && (good_hit || idle_hit)) |=> !iso); // R6
endmodule

// File: rtl/fcar_isolate_mon.sv
module fcar_isolate_mon #(
  parameter int CNT_W   = 8,
  parameter int STAT_W  = 16,
  parameter int LONG_BT = 484,
  parameter int GOOD_BT = 480,
  parameter int IDLE_BT = 27500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              carrier_on,
  input  logic              false_car,
  input  logic              good_frame,
  input  logic              idle_sym,
  input  logic              rptr_en,
  input  logic              disc_en,
  input  logic              stat_rd,
  output logic              mii_isolate,
  output logic [STAT_W-1:0] stat_word
);
  localparam int PAD_W = STAT_W - 1 - CNT_W;

  logic             en, fc_ev, in_false, dis_evt, iso;
  logic             long_hit, good_hit, idle_hit;
  logic             long_run, good_run, idle_run;
  logic [CNT_W-1:0] cnt;
  logic             sticky;

  assign en    = rptr_en && disc_en;
  assign fc_ev = false_car && carrier_on;

  assign long_run = in_false && carrier_on && en && !iso;
  assign good_run = iso && carrier_on && !in_false && !fc_ev;
  assign idle_run = iso && idle_sym && !carrier_on;

  fcm_bit_timer #(.LIMIT(LONG_BT)) u_long (
    .clk(clk), .rst(rst), .run(long_run), .tick(bit_tick), .hit(long_hit));
  fcm_bit_timer #(.LIMIT(GOOD_BT)) u_good (
    .clk(clk), .rst(rst), .run(good_run), .tick(bit_tick), .hit(good_hit));
  fcm_bit_timer #(.LIMIT(IDLE_BT)) u_idle (
    .clk(clk), .rst(rst), .run(idle_run), .tick(bit_tick), .hit(idle_hit));

  fcm_iso_ctl u_ctl (
    .clk(clk), .rst(rst), .en(en), .carrier_on(carrier_on), .fc_ev(fc_ev),
    .good_frame(good_frame), .long_hit(long_hit), .good_hit(good_hit),
    .idle_hit(idle_hit), .iso(iso), .in_false(in_false), .dis_evt(dis_evt));

  fcm_evt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(fc_ev), .rd(stat_rd), .dis_evt(dis_evt),
    .cnt_o(cnt), .sticky_o(sticky));

  assign mii_isolate = iso;

  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_word = {sticky, {PAD_W{1'b0}}, cnt};
    end else begin : g_nopad
      assign stat_word = {sticky, cnt};
    end
  endgenerate

  AST_STICKY_ON_ISO: assert property (@(posedge clk) disable iff (rst)
    $rose(mii_isolate) |-> stat_word[STAT_W-1]); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_word[STAT_W-2:CNT_W] == '0); // R10
endmodule

// File: tb/sim_fcar_isolate_mon.sv
module sim_fcar_isolate_mon;
  logic clk = 1'b0;
  logic rst, bit_tick, carrier_on, false_car, good_frame, idle_sym;
  logic rptr_en, disc_en, stat_rd;
  logic mii_isolate;
  logic [15:0] stat_word;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fcar_isolate_mon u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .carrier_on(carrier_on),
    .false_car(false_car), .good_frame(good_frame), .idle_sym(idle_sym),
    .rptr_en(rptr_en), .disc_en(disc_en), .stat_rd(stat_rd),
    .mii_isolate(mii_isolate), .stat_word(stat_word));

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic r_en, input logic d_en);
    rst = 1'b1; bit_tick = 0; carrier_on = 0; false_car = 0; good_frame = 0;
    idle_sym = 0; stat_rd = 0; rptr_en = r_en; disc_en = d_en;
    cyc(); cyc();
    rst = 1'b0;
    cyc();
  endtask

  task automatic false_evt();
    carrier_on = 1; false_car = 1; cyc();
    false_car = 0; cyc();
    carrier_on = 0; cyc();
  endtask

  task automatic t_reset();
    do_reset(1, 1);
    chk("R1 iso", {15'd0, mii_isolate}, 16'd0);
    chk("R1 stat", stat_word, 16'd0);
  endtask

  task automatic t_enable();
    do_reset(1, 0);
    false_evt(); false_evt();
    chk("R2 disc_en low", {15'd0, mii_isolate}, 16'd0);
    chk("R8 count w/o enable", stat_word, 16'd2);
    do_reset(0, 1);
    false_evt(); false_evt();
    chk("R2 rptr_en low", {15'd0, mii_isolate}, 16'd0);
  endtask

  task automatic t_consec();
    do_reset(1, 1);
    false_evt();
    chk("R3 one event", {15'd0, mii_isolate}, 16'd0);
    carrier_on = 1; false_car = 1; cyc();
    false_car = 0;
    chk("R3 iso", {15'd0, mii_isolate}, 16'd1);
    chk("R3 sticky+count", stat_word, 16'h8002);
    carrier_on = 0; cyc();
    disc_en = 0; cyc();
    chk("R2 drop enable", {15'd0, mii_isolate}, 16'd0);
  endtask

  task automatic t_goodfrm();
    do_reset(1, 1);
    false_evt();
    good_frame = 1; cyc(); good_frame = 0;
    false_evt();
    chk("R4 good frame between", {15'd0, mii_isolate}, 16'd0);
    chk("R4 count", stat_word, 16'd2);
  endtask

  task automatic t_long();
    do_reset(1, 1);
    carrier_on = 1; false_car = 1; cyc();
    false_car = 0; bit_tick = 1;
    repeat (483) cyc();
    chk("R5 483 ticks", {15'd0, mii_isolate}, 16'd0);
    cyc();
    chk("R5 484 ticks", {15'd0, mii_isolate}, 16'd1);
    chk("R5 sticky", stat_word, 16'h8001);
    bit_tick = 0; carrier_on = 0; cyc();
  endtask

  task automatic isolate();
    false_evt();
    carrier_on = 1; false_car = 1; cyc();
    false_car = 0; carrier_on = 0; cyc();
  endtask

  task automatic t_goodcar();
    do_reset(1, 1);
    isolate();
    carrier_on = 1; false_car = 1; cyc();
    false_car = 0; bit_tick = 1;
    repeat (600) cyc();
    chk("R6 false carrier no reconnect", {15'd0, mii_isolate}, 16'd1);
    bit_tick = 0; carrier_on = 0; cyc();
    carrier_on = 1; bit_tick = 1;
    repeat (479) cyc();
    chk("R6 479 ticks", {15'd0, mii_isolate}, 16'd1);
    cyc();
    chk("R6 480 ticks", {15'd0, mii_isolate}, 16'd0);
    bit_tick = 0; carrier_on = 0; cyc();
  endtask

  task automatic t_idle();
    do_reset(1, 1);
    isolate();
    idle_sym = 1; bit_tick = 1;
    repeat (20000) cyc();
    carrier_on = 1; cyc(); carrier_on = 0;
    chk("R7 window broken", {15'd0, mii_isolate}, 16'd1);
    repeat (27499) cyc();
    chk("R7 27499 ticks", {15'd0, mii_isolate}, 16'd1);
    cyc();
    chk("R7 27500 ticks", {15'd0, mii_isolate}, 16'd0);
    idle_sym = 0; bit_tick = 0; cyc();
  endtask

  task automatic t_sat();
    do_reset(0, 0);
    carrier_on = 1; false_car = 1;
    repeat (260) cyc();
    false_car = 0; carrier_on = 0;
    chk("R8 saturate", stat_word, 16'd255);
    chk("R10 pad bits", {9'd0, stat_word[14:8]}, 16'd0);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 read clears", stat_word, 16'd0);
  endtask

  task automatic t_rdcol();
    do_reset(1, 1);
    false_evt();
    chk("R8 one event", stat_word, 16'd1);
    carrier_on = 1; false_car = 1; stat_rd = 1; cyc();
    false_car = 0; stat_rd = 0;
    chk("R9 collide iso", {15'd0, mii_isolate}, 16'd1);
    chk("R9 collide word", stat_word, 16'h8001);
    carrier_on = 0;
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 quiet read", stat_word, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_consec();
    t_goodfrm();
    t_long();
    t_goodcar();
    t_idle();
    t_sat();
    t_rdcol();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule